// File: doc/BRIEF.md
# Iterative Image Stream Buffer

The block holds one image in on-chip memory and runs it through an external processing engine a number of times chosen at run time. In each pass every image word is read in address order and sent on an outbound stream. The engine returns the processed words on an inbound stream, and the block writes them back to the addresses they came from. The outbound and inbound sides share the memory at the same time. Each side has its own pointer and stalls on its own handshake. The inbound pointer trails the outbound one by however many cycles the engine takes.

A pass is complete only when both pointers have covered the whole image. The next pass therefore never reads a word before its update has been stored. After the last pass, the image is read once more, in order, onto a separate upload stream. A one-cycle completion pulse follows the final upload word.

Before a run, the image is placed through a simple word-write port, which is accepted only while the block is idle.

Top module: `img_pass_buffer`

## Requirements
- R1: After reset, `busy`, `done`, `out_tvalid`, `up_tvalid` and `in_tready` are all low.
- R2: While idle, a cycle with `load_en` high stores `load_data` at `load_addr`. While busy, `load_en` has no effect on the image.
- R3: A `start` pulse while idle captures `num_passes` as the pass count N. A `start` pulse while busy is ignored and does not change N.
- R4: In each pass, the outbound stream carries exactly DEPTH beats. Beat k of a pass carries the word stored at address k, and `out_tlast` is high only on beat DEPTH-1.
- R5: Inbound beats of a pass are written to addresses 0, 1, 2, … in turn. `in_tready` is low while idle, during upload, and once DEPTH inbound beats of the current pass have been taken.
- R6: Under backpressure, `out_tvalid`, `out_tdata` and `out_tlast` hold until accepted. No word is lost or repeated, and the outbound and inbound sides stall independently.
- R7: A new pass starts only after both the outbound and inbound sides have covered the whole image. Pass p+1 therefore sends the words written back during pass p, even when the engine latency exceeds DEPTH.
- R8: After N passes, the upload stream carries the DEPTH image words in address order, with `up_tlast` on the last one, and holds its outputs under backpressure.
- R9: `done` is high for exactly one cycle: the cycle after the final upload word is accepted. `busy` is low in that cycle.
- R10: With N = 0, no outbound beats are sent and the upload carries the image as loaded.
- R11: `out_tvalid` and `up_tvalid` are never high together. With no backpressure, each side moves one word per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Write one image word (honoured only while idle) |
| load_addr | input | ADDR_W | Address of the loaded word |
| load_data | input | DATA_W | Loaded word |
| start | input | 1 | Begin a run (honoured only while idle) |
| num_passes | input | PASS_W | Number of engine passes N for this run |
| out_tdata | output | DATA_W | Outbound stream data to the engine |
| out_tvalid | output | 1 | Outbound valid |
| out_tready | input | 1 | Outbound ready from the engine |
| out_tlast | output | 1 | High on the last word of a pass |
| in_tdata | input | DATA_W | Processed word returned by the engine |
| in_tvalid | input | 1 | Inbound valid |
| in_tready | output | 1 | Inbound ready |
| up_tdata | output | DATA_W | Upload stream data |
| up_tvalid | output | 1 | Upload valid |
| up_tready | input | 1 | Upload ready |
| up_tlast | output | 1 | High on the last image word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the final upload word |

## Verification
The outbound memory read of one word and the inbound write-back of an earlier word fall in the same cycle throughout a pass. The end of the outbound side of a pass can also coincide with inbound words still arriving.

The bench provokes both cases with an engine model whose latency ranges from one cycle (reads and writes interleave on every cycle) to more than the image depth (the outbound side finishes long before the inbound side). It does so under several independent ready and valid patterns.

Each outbound word of pass p is judged against the loaded value plus p, which only holds if every write-back of pass p-1 landed before it was read. The upload is judged against the loaded value plus N.

// File: rtl/ibuf_pkg.sv
// Shared types for the iterative image stream buffer.
package ibuf_pkg;
    // Top-level operating phase.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_PASS   = 2'd1,
        PH_UPLOAD = 2'd2
    } phase_t;
endpackage

// File: rtl/ibuf_ram.sv
// Image store: one read port and one write port, both synchronous.
// Read data appears one cycle after rd_en. A read and a write to the same
// address in the same cycle return the old word.
// Assumes the caller never issues two reads in one cycle.
module ibuf_ram #(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] store_q [DEPTH];

    // Registered read and write on the same edge; the read sees the old contents.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= store_q[rd_addr];
        if (wr_en) store_q[wr_addr] <= wr_data;
    end
endmodule

// File: rtl/ibuf_reader.sv
// Sequential image reader with a two-entry skid store.
// On kick, it walks addresses 0..DEPTH-1 once, issuing memory reads only while
// the skid store plus the read in flight leave room. Each returned word is
// queued with a last flag, so a low m_tready never loses or repeats a word.
// Assumes kick arrives only while idle_o is high.
module ibuf_reader #(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast,
    output logic              idle_o
);
    localparam logic [ADDR_W:0]   FULL_CNT = (ADDR_W+1)'(DEPTH);
    localparam logic [ADDR_W-1:0] LAST_A   = ADDR_W'(DEPTH - 1);

    logic [ADDR_W:0]   left_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              inflight_q;
    logic              last_pend_q;
    logic [DATA_W:0]   slot_q [2];
    logic              wsel_q, rsel_q;
    logic [1:0]        cnt_q;
    logic              pop, issue;
    logic [2:0]        occ;

    // Decide whether a new memory read fits behind the queued words.
    always_comb begin
        pop   = (cnt_q != 2'd0) && m_tready;
        occ   = {1'b0, cnt_q} + {2'b00, inflight_q};
        issue = (left_q != '0) && (occ < (3'd2 + {2'b00, pop}));
    end

    assign rd_en    = issue;
    assign rd_addr  = ptr_q;
    assign m_tvalid = (cnt_q != 2'd0);
    assign m_tdata  = slot_q[rsel_q][DATA_W-1:0];
    assign m_tlast  = slot_q[rsel_q][DATA_W];
    assign idle_o   = (left_q == '0) && (cnt_q == 2'd0) && !inflight_q;

    // Address walk, in-flight tracking and skid occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q      <= '0;
            ptr_q       <= '0;
            inflight_q  <= 1'b0;
            last_pend_q <= 1'b0;
            wsel_q      <= 1'b0;
            rsel_q      <= 1'b0;
            cnt_q       <= 2'd0;
        end else begin
            if (kick) begin
                left_q <= FULL_CNT;
                ptr_q  <= '0;
            end else if (issue) begin
                left_q <= left_q - (ADDR_W+1)'(1);
                ptr_q  <= (ptr_q == LAST_A) ? '0 : ptr_q + ADDR_W'(1);
            end
            inflight_q  <= issue;
            last_pend_q <= issue && (ptr_q == LAST_A);
            if (inflight_q) wsel_q <= ~wsel_q;
            if (pop)        rsel_q <= ~rsel_q;
            cnt_q <= cnt_q + {1'b0, inflight_q} - {1'b0, pop};
        end
    end

    // Capture returning memory words into the skid store.
    always_ff @(posedge clk) begin
        if (inflight_q) slot_q[wsel_q] <= {last_pend_q, rd_data};
    end
endmodule

// File: rtl/ibuf_inbound.sv
// Inbound write-back side: takes one processed word per handshake and writes
// it to the next address, starting from zero at each kick. It accepts exactly
// DEPTH words per kick and drops ready afterwards.
// Assumes kick arrives only while all_in is high.
module ibuf_inbound #(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              all_in
);
    localparam logic [ADDR_W:0]   FULL_CNT = (ADDR_W+1)'(DEPTH);
    localparam logic [ADDR_W-1:0] LAST_A   = ADDR_W'(DEPTH - 1);

    logic [ADDR_W:0]   left_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              fire;

    assign s_tready = (left_q != '0);
    assign fire     = s_tvalid && s_tready;
    assign wr_en    = fire;
    assign wr_addr  = ptr_q;
    assign wr_data  = s_tdata;
    assign all_in   = (left_q == '0);

    // Write pointer and remaining-word count for the current pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            ptr_q  <= '0;
        end else if (kick) begin
            left_q <= FULL_CNT;
            ptr_q  <= '0;
        end else if (fire) begin
            left_q <= left_q - (ADDR_W+1)'(1);
            ptr_q  <= (ptr_q == LAST_A) ? '0 : ptr_q + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/img_pass_buffer.sv
// Iterative image stream buffer, top level.
// Idle: accepts image loads and a start pulse.
// Pass phase: the outbound reader and the inbound writer run together over
// the image; the pass ends when both have covered every word.
// Upload phase: after N passes, a second reader streams the image once.
// Assumes DEPTH >= 2 and that the engine returns exactly one word per word sent.
module img_pass_buffer
    import ibuf_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 1024,
    parameter int PASS_W = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              start,
    input  logic [PASS_W-1:0] num_passes,
    output logic [DATA_W-1:0] out_tdata,
    output logic              out_tvalid,
    input  logic              out_tready,
    output logic              out_tlast,
    input  logic [DATA_W-1:0] in_tdata,
    input  logic              in_tvalid,
    output logic              in_tready,
    output logic [DATA_W-1:0] up_tdata,
    output logic              up_tvalid,
    input  logic              up_tready,
    output logic              up_tlast,
    output logic              busy,
    output logic              done
);
    phase_t            phase_q;
    logic [PASS_W-1:0] passes_q, pass_idx_q;
    logic              done_q;

    logic              out_rd_en, up_rd_en, in_wr_en;
    logic [ADDR_W-1:0] out_rd_addr, up_rd_addr, in_wr_addr;
    logic [DATA_W-1:0] in_wr_data, ram_rd_data;
    logic              out_idle, up_idle, in_all;
    logic              ram_rd_en, ram_wr_en;
    logic [ADDR_W-1:0] ram_rd_addr, ram_wr_addr;
    logic [DATA_W-1:0] ram_wr_data;
    logic              accept_start, pass_end, last_pass;
    logic              go_pass, go_upload, up_final;

    // Phase transition conditions.
    always_comb begin
        accept_start = (phase_q == PH_IDLE) && start && up_idle;
        pass_end     = (phase_q == PH_PASS) && out_idle && in_all;
        last_pass    = (pass_idx_q == passes_q - PASS_W'(1));
        go_pass      = (accept_start && (num_passes != '0)) || (pass_end && !last_pass);
        go_upload    = (accept_start && (num_passes == '0)) || (pass_end && last_pass);
        up_final     = up_tvalid && up_tready && up_tlast;
    end

    // Memory port sharing: upload owns the read port in its phase; loads write only while idle.
    always_comb begin
        ram_rd_en   = out_rd_en || up_rd_en;
        ram_rd_addr = (phase_q == PH_UPLOAD) ? up_rd_addr : out_rd_addr;
        ram_wr_en   = in_wr_en || (load_en && (phase_q == PH_IDLE));
        ram_wr_addr = in_wr_en ? in_wr_addr : load_addr;
        ram_wr_data = in_wr_en ? in_wr_data : load_data;
    end

    // Phase register, pass counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            passes_q   <= '0;
            pass_idx_q <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= (phase_q == PH_UPLOAD) && up_final;
            case (phase_q)
                PH_IDLE: if (accept_start) begin
                    passes_q   <= num_passes;
                    pass_idx_q <= '0;
                    phase_q    <= (num_passes == '0) ? PH_UPLOAD : PH_PASS;
                end
                PH_PASS: if (pass_end) begin
                    if (last_pass) phase_q <= PH_UPLOAD;
                    else           pass_idx_q <= pass_idx_q + PASS_W'(1);
                end
                PH_UPLOAD: if (up_final) phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase_q != PH_IDLE);
    assign done = done_q;

    ibuf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .rd_en   (ram_rd_en),
        .rd_addr (ram_rd_addr),
        .rd_data (ram_rd_data),
        .wr_en   (ram_wr_en),
        .wr_addr (ram_wr_addr),
        .wr_data (ram_wr_data)
    );

    ibuf_reader #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_out_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick     (go_pass),
        .rd_en    (out_rd_en),
        .rd_addr  (out_rd_addr),
        .rd_data  (ram_rd_data),
        .m_tdata  (out_tdata),
        .m_tvalid (out_tvalid),
        .m_tready (out_tready),
        .m_tlast  (out_tlast),
        .idle_o   (out_idle)
    );

    ibuf_inbound #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_in_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick     (go_pass),
        .s_tdata  (in_tdata),
        .s_tvalid (in_tvalid),
        .s_tready (in_tready),
        .wr_en    (in_wr_en),
        .wr_addr  (in_wr_addr),
        .wr_data  (in_wr_data),
        .all_in   (in_all)
    );

    ibuf_reader #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_up_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick     (go_upload),
        .rd_en    (up_rd_en),
        .rd_addr  (up_rd_addr),
        .rd_data  (ram_rd_data),
        .m_tdata  (up_tdata),
        .m_tvalid (up_tvalid),
        .m_tready (up_tready),
        .m_tlast  (up_tlast),
        .idle_o   (up_idle)
    );
endmodule

// File: rtl/img_pass_buffer_chk.sv
// Protocol checker for img_pass_buffer, attached by bind.
// It observes only the ports of the top module.
module img_pass_buffer_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] out_tdata,
    input logic              out_tvalid,
    input logic              out_tready,
    input logic              out_tlast,
    input logic              in_tready,
    input logic [DATA_W-1:0] up_tdata,
    input logic              up_tvalid,
    input logic              up_tready,
    input logic              up_tlast,
    input logic              busy,
    input logic              done
);
    // R5: no inbound acceptance outside a run.
    p_idle_no_inbound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !in_tready);

    // R6: a stalled outbound word holds.
    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tvalid && !out_tready) |=> (out_tvalid && $stable(out_tdata) && $stable(out_tlast)));

    // R8: a stalled upload word holds.
    p_up_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_tvalid && !up_tready) |=> (up_tvalid && $stable(up_tdata) && $stable(up_tlast)));

    // R9: the completion pulse is one cycle long.
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the completion pulse follows the accepted final upload word, with busy low.
    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(up_tvalid && up_tready && up_tlast) && !busy));

    // R11: the two read streams are never valid together.
    p_streams_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_tvalid && up_tvalid));
endmodule

bind img_pass_buffer img_pass_buffer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_tdata  (out_tdata),
    .out_tvalid (out_tvalid),
    .out_tready (out_tready),
    .out_tlast  (out_tlast),
    .in_tready  (in_tready),
    .up_tdata   (up_tdata),
    .up_tvalid  (up_tvalid),
    .up_tready  (up_tready),
    .up_tlast   (up_tlast),
    .busy       (busy),
    .done       (done)
);

// File: tb/img_pass_buffer_tb.sv
`timescale 1ns/1ps
// Bench: an engine model with configurable latency returns each outbound word
// plus one. A vector table sets pass count, latency and handshake patterns.
module img_pass_buffer_tb;
    localparam int DW = 128;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);
    localparam int PW = 16;
    localparam int NV = 6;
    // Vector fields: [31:24] passes, [23:16] engine latency,
    // [15:12] outbound-ready pattern, [11:8] inbound-valid pattern, [7:4] upload-ready pattern.
    localparam logic [31:0] VEC [NV] = '{
        32'h0302_0000, 32'h0205_1210, 32'h0114_2030,
        32'h0001_0020, 32'h0403_3300, 32'h0201_0110
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic load_en = 1'b0, start = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [DW-1:0] load_data = '0, in_tdata = '0;
    logic [PW-1:0] num_passes = '0;
    logic out_tready = 1'b0, in_tvalid = 1'b0, up_tready = 1'b0;
    logic [DW-1:0] out_tdata, up_tdata;
    logic out_tvalid, out_tlast, in_tready, up_tvalid, up_tlast, busy, done;

    int n_checks = 0, n_fail = 0, gcyc = 0;
    logic [DW-1:0] q_data [$];
    int q_time [$];

    always #2.5 clk = ~clk;

    img_pass_buffer #(.DATA_W(DW), .DEPTH(DEPTH), .PASS_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .start(start), .num_passes(num_passes),
        .out_tdata(out_tdata), .out_tvalid(out_tvalid), .out_tready(out_tready),
        .out_tlast(out_tlast), .in_tdata(in_tdata), .in_tvalid(in_tvalid),
        .in_tready(in_tready), .up_tdata(up_tdata), .up_tvalid(up_tvalid),
        .up_tready(up_tready), .up_tlast(up_tlast), .busy(busy), .done(done)
    );

    function automatic logic [DW-1:0] img(int v, int k);
        return {32'hC0DE0000 + 32'(v), 64'h0123_4567_89AB_CDEF ^ {32'(k), 32'(k * 3)}, 32'(k * 16)};
    endfunction

    function automatic logic pat(int m, int c);
        case (m)
            0: return 1'b1;
            1: return (c % 3) != 2;
            2: return ((c * 7 + c / 5) % 4) != 0;
            default: return (c % 16) < 9;
        endcase
    endfunction

    task automatic check(string req, logic ok, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_image(int v);
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            load_en = 1'b1; load_addr = AW'(k); load_data = img(v, k);
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // One run: start, drive all streams cycle by cycle until done, check every beat.
    task automatic run_vec(int v, int np, int lat, int om, int im, int um, bit inject, bit time_it);
        int ob = 0, ub = 0, c = 0, t_start = 0;
        bit exp_done = 1'b0, saw_done = 1'b0, both = 1'b0;
        q_data.delete(); q_time.delete();
        while (1) begin
            @(negedge clk);
            gcyc++;
            start = (c == 0) || (inject && c == 30);
            num_passes = (inject && c == 30) ? PW'(np + 3) : PW'(np);
            load_en = inject && (c == 30);
            load_addr = AW'(5);
            load_data = {DW{1'b1}};
            out_tready = pat(om, gcyc);
            up_tready = pat(um, gcyc);
            in_tvalid = (q_data.size() != 0) && (q_time[0] <= gcyc) && pat(im, gcyc);
            in_tdata = (q_data.size() != 0) ? q_data[0] + DW'(1) : '0;
            if (c == 0) t_start = gcyc;
            #1;
            if (exp_done || done) begin
                check("R9 done after final upload word", done == exp_done, DW'(done), DW'(exp_done));
                if (done) begin
                    check("R9 busy low with done", !busy, DW'(busy), '0);
                    saw_done = 1'b1;
                    break;
                end
            end
            exp_done = 1'b0;
            if (out_tvalid && up_tvalid) both = 1'b1;
            if (out_tvalid && out_tready) begin
                int idx = ob % DEPTH, p = ob / DEPTH;
                check("R4/R7 outbound word", out_tdata == img(v, idx) + DW'(p), out_tdata, img(v, idx) + DW'(p));
                check("R4 outbound tlast", out_tlast == (idx == DEPTH - 1), DW'(out_tlast), DW'(idx == DEPTH - 1));
                q_data.push_back(out_tdata);
                q_time.push_back(gcyc + lat);
                ob++;
            end
            if (in_tvalid && in_tready) begin
                void'(q_data.pop_front());
                void'(q_time.pop_front());
            end
            if (up_tvalid && up_tready) begin
                check("R8 upload word", up_tdata == img(v, ub) + DW'(np), up_tdata, img(v, ub) + DW'(np));
                check("R8 upload tlast", up_tlast == (ub == DEPTH - 1), DW'(up_tlast), DW'(ub == DEPTH - 1));
                if (up_tlast) exp_done = 1'b1;
                ub++;
            end
            c++;
            if (c > 4000) break;
        end
        @(negedge clk);
        start = 1'b0; load_en = 1'b0; in_tvalid = 1'b0;
        check("R9 run completed", saw_done, DW'(saw_done), DW'(1));
        check("R3/R10 outbound beat count", ob == np * DEPTH, DW'(ob), DW'(np * DEPTH));
        check("R8 upload beat count", ub == DEPTH, DW'(ub), DW'(DEPTH));
        check("R5/R6 every word returned", q_data.size() == 0, DW'(q_data.size()), '0);
        check("R11 streams exclusive", !both, DW'(both), '0);
        check("R5 inbound closed after run", !in_tready && !busy, DW'({in_tready, busy}), '0);
        if (time_it)
            check("R11 full-rate throughput", (gcyc - t_start) <= np * (DEPTH + lat + 8) + DEPTH + 8,
                  DW'(gcyc - t_start), DW'(np * (DEPTH + lat + 8) + DEPTH + 8));
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state, R5 inbound closed.
        check("R1 reset outputs", !busy && !done && !out_tvalid && !up_tvalid,
              DW'({busy, done, out_tvalid, up_tvalid}), '0);
        check("R5 in_tready low after reset", !in_tready, DW'(in_tready), '0);

        // Table walk: R2 loading, R4..R8 per pass, R10 with zero passes, R11 timing on entry 0.
        for (int i = 0; i < NV; i++) begin
            load_image(i);
            run_vec(i, int'(VEC[i][31:24]), int'(VEC[i][23:16]), int'(VEC[i][15:12]),
                    int'(VEC[i][11:8]), int'(VEC[i][7:4]), 1'b0, i == 0);
        end

        // R2 and R3: a load and a restart while busy are both ignored.
        load_image(7);
        run_vec(7, 2, 2, 1, 0, 0, 1'b1, 1'b0);

        // R10 again after a run, with a slow upload.
        load_image(8);
        run_vec(8, 0, 1, 0, 0, 3, 1'b0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule